// File: doc/BRIEF.md
# Multiplexed Bus Address-Phase Controller

This block sequences the address phase of a small processor's external bus, where the low sixteen address bits and the data share one set of lines. Each accepted bus cycle produces one address-phase clock and then one data-phase clock. The full 20-bit address always appears on a separate set of address pins. Whether the address also appears on the shared lines is decided per cycle.

A strap pin is captured while reset is held and keeps its value until the next reset. With the strap low, the shared lines always carry the address. With the strap high, each of the two memory regions, upper and lower, has its own suppress bit. When a cycle selects a region whose bit is set, the shared lines float during the address phase. All other cycles drive the address.

DRAM refresh cycles are marked by driving both the byte-high-enable pin and shared line 0 high. Line 0 of the shared bus therefore identifies a refresh, and it may differ from address bit 0 on the separate pins.

Top module: `mbap_top`

## Requirements
- R1: The strap level present at the last clock edge while `rst_n` is low is kept until the next reset. Changes on `strap_in` after reset release have no effect.
- R2: With the strap high, an address phase whose cycle selects the upper region, or the lower region without the upper one, drives the shared lines (`ad_oe`=1, `ad_out` = address bits 15..0) only when that region's suppress bit is 0. Otherwise it gives `ad_oe`=0 and `ad_out`=0. The upper select takes precedence when both are asserted.
- R3: With the strap low, every address phase drives the shared lines, whatever the suppress bits hold.
- R4: A cycle that selects neither the upper nor the lower region always drives the address on the shared lines.
- R5: During the address, data and following idle clocks, `a_out` carries the full 20-bit address that was sampled when the cycle was accepted.
- R6: A refresh cycle (`cyc_kind`=2'b10) drives the shared lines in its address phase, with `ad_out[0]`=1, `ad_out[15:1]` = address bits 15..1 and `bhe_n`=1, regardless of strap, selects and suppress bits.
- R7: A `cyc_start` that is sampled while idle gives exactly one address-phase clock, beginning at the next edge, and then one data-phase clock. In the data phase a write (`cyc_kind`=2'b01) drives `wdata` with `ad_oe`=1. Reads (2'b00, 2'b11) and refresh release the lines (`ad_oe`=0, `ad_out`=0). After the data phase the block returns to idle: `ad_oe`=0, `ad_out`=0, `bhe_n`=1.
- R8: A `cyc_start` that arrives during the address or data phase is ignored. The phases in progress and `a_out` are unaffected.
- R9: Both suppress bits reset to 0. Each is loaded from `cfg_dis_bit` when its write strobe is high. A cycle accepted at the same edge as a write uses the value held before that write.
- R10: In a non-refresh cycle, `bhe_n` equals the inverse of `byte_hi` sampled at cycle start, throughout the address and data phases.
- R11: While in reset, the outputs are `ad_oe`=0, `ad_out`=0, `a_out`=0 and `bhe_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (asynchronous assert) |
| strap_in | input | 1 | Strap level captured while in reset |
| cfg_upper_we | input | 1 | Write strobe for the upper-region suppress bit |
| cfg_lower_we | input | 1 | Write strobe for the lower-region suppress bit |
| cfg_dis_bit | input | 1 | Value written to the suppress bit |
| cyc_start | input | 1 | Request to begin a bus cycle |
| cyc_kind | input | 2 | 00 read, 01 write, 10 refresh, 11 read |
| sel_upper | input | 1 | Cycle targets the upper memory region |
| sel_lower | input | 1 | Cycle targets the lower memory region |
| byte_hi | input | 1 | Cycle uses the high byte |
| addr | input | 20 | Cycle address |
| wdata | input | 16 | Write data |
| a_out | output | 20 | Separate address pins |
| ad_out | output | 16 | Shared address/data line values |
| ad_oe | output | 1 | Drive enable for the shared lines |
| bhe_n | output | 1 | Byte-high-enable, active low |

## Verification
Two functions can act in the same cycle: a refresh cycle that selects a region whose suppress bit is set under a high strap, and a suppress-bit write that lands on the same edge as a cycle start. The bench sets up both on purpose, and the random stimulus also hits them often. It then judges the address-phase outputs against a model in which refresh always drives with its marker and the accepted cycle sees the suppress value from before the write. A start pulse is also sent during a busy cycle, together with a changed address, to show that both are ignored.

// File: rtl/mbap_pkg.sv
package mbap_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;

    localparam logic [1:0] CK_READ    = 2'b00;
    localparam logic [1:0] CK_WRITE   = 2'b01;
    localparam logic [1:0] CK_REFRESH = 2'b10;

    localparam int unsigned N_REGIONS = 2;
    localparam int unsigned RG_UPPER  = 0;
    localparam int unsigned RG_LOWER  = 1;

endpackage

// File: rtl/mbap_strap_capture.sv
module mbap_strap_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic strap_q
);

    logic strap_d;

    // Load continuously while reset is held; freeze once released.
    always_comb begin
        strap_d = strap_q;
        if (!rst_n) begin
            strap_d = strap_in;
        end
    end

    always_ff @(posedge clk) begin
        strap_q <= strap_d;
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q)); // R1

endmodule

// File: rtl/mbap_cfg_regs.sv
module mbap_cfg_regs
    import mbap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_REGIONS-1:0] we,
    input  logic                 wbit,
    output logic [N_REGIONS-1:0] dis_q
);

    typedef struct packed {
        logic [N_REGIONS-1:0] dis;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (we[i]) begin
                cfg_d.dis[i] = wbit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dis_q = cfg_q.dis;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_chk
        AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !we[g] |=> $stable(dis_q[g])); // R9
        AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            we[g] |=> (dis_q[g] == $past(wbit))); // R9
    end

endmodule

// File: rtl/mbap_drive_policy.sv
module mbap_drive_policy
    import mbap_pkg::*;
(
    input  logic                 strap,
    input  logic                 sel_upper,
    input  logic                 sel_lower,
    input  logic [N_REGIONS-1:0] dis,
    input  logic                 is_refresh,
    output logic                 drive_addr
);

    logic region_dis;

    always_comb begin
        if (sel_upper) begin
            region_dis = dis[RG_UPPER];
        end else if (sel_lower) begin
            region_dis = dis[RG_LOWER];
        end else begin
            region_dis = 1'b0;
        end
        drive_addr = is_refresh | ~(strap & region_dis);
    end

    always_comb begin
        if (!strap) begin
            AST_STRAP_LOW_DRIVES: assert (drive_addr); // R3
        end
    end

endmodule

// File: rtl/mbap_top.sv
module mbap_top
    import mbap_pkg::*;
#(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_in,
    input  logic          cfg_upper_we,
    input  logic          cfg_lower_we,
    input  logic          cfg_dis_bit,
    input  logic          cyc_start,
    input  logic [1:0]    cyc_kind,
    input  logic          sel_upper,
    input  logic          sel_lower,
    input  logic          byte_hi,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] a_out,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          bhe_n
);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] a;
        logic [DW-1:0] ad;
        logic          oe;
        logic          bhe_n;
        logic          wr;
        logic          rf;
        logic [DW-1:0] wd;
    } bus_state_t;

    bus_state_t st_d, st_q;

    logic                 strap_q;
    logic [N_REGIONS-1:0] dis_q;
    logic [N_REGIONS-1:0] cfg_we;
    logic                 is_refresh;
    logic                 is_write;
    logic                 drive_addr;

    assign cfg_we[RG_UPPER] = cfg_upper_we;
    assign cfg_we[RG_LOWER] = cfg_lower_we;
    assign is_refresh = (cyc_kind == CK_REFRESH);
    assign is_write   = (cyc_kind == CK_WRITE);

    mbap_strap_capture u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .strap_q  (strap_q)
    );

    mbap_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wbit  (cfg_dis_bit),
        .dis_q (dis_q)
    );

    mbap_drive_policy u_policy (
        .strap      (strap_q),
        .sel_upper  (sel_upper),
        .sel_lower  (sel_lower),
        .dis        (dis_q),
        .is_refresh (is_refresh),
        .drive_addr (drive_addr)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cyc_start) begin
                    st_d.phase = PH_ADDR;
                    st_d.a     = addr;
                    st_d.oe    = drive_addr;
                    st_d.ad    = drive_addr ? {addr[DW-1:1], addr[0] | is_refresh} : '0;
                    st_d.bhe_n = is_refresh ? 1'b1 : ~byte_hi;
                    st_d.wr    = is_write;
                    st_d.rf    = is_refresh;
                    st_d.wd    = wdata;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_DATA;
                st_d.oe    = st_q.wr;
                st_d.ad    = st_q.wr ? st_q.wd : '0;
            end
            PH_DATA: begin
                st_d.phase = PH_IDLE;
                st_d.oe    = 1'b0;
                st_d.ad    = '0;
                st_d.bhe_n = 1'b1;
                st_d.wr    = 1'b0;
                st_d.rf    = 1'b0;
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.oe    = 1'b0;
                st_d.ad    = '0;
                st_d.bhe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.bhe_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_out  = st_q.a;
    assign ad_out = st_q.ad;
    assign ad_oe  = st_q.oe;
    assign bhe_n  = st_q.bhe_n;

    AST_ADDR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ADDR) |=> (st_q.phase == PH_DATA)); // R7
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA && !st_q.wr) |-> (!ad_oe && ad_out == '0)); // R7
    AST_ADDR_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ADDR) |-> (a_out == $past(addr))); // R5
    AST_REFRESH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ADDR && st_q.rf) |-> (ad_oe && bhe_n && ad_out[0])); // R6
    AST_STRAP_LOW_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ADDR && !strap_q) |-> ad_oe); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |=> (st_q.phase != PH_ADDR)); // R8
    AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '0)); // R2

endmodule

// File: tb/mbap_top_test.sv
module mbap_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_in = 1'b1;
    logic        cfg_upper_we = 1'b0;
    logic        cfg_lower_we = 1'b0;
    logic        cfg_dis_bit = 1'b0;
    logic        cyc_start = 1'b0;
    logic [1:0]  cyc_kind = 2'b00;
    logic        sel_upper = 1'b0;
    logic        sel_lower = 1'b0;
    logic        byte_hi = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [19:0] a_out;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic        bhe_n;

    int checks = 0;
    int failures = 0;

    logic m_strap;
    logic m_up_dis;
    logic m_lo_dis;

    always #2.5 clk = ~clk;

    mbap_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_in     (strap_in),
        .cfg_upper_we (cfg_upper_we),
        .cfg_lower_we (cfg_lower_we),
        .cfg_dis_bit  (cfg_dis_bit),
        .cyc_start    (cyc_start),
        .cyc_kind     (cyc_kind),
        .sel_upper    (sel_upper),
        .sel_lower    (sel_lower),
        .byte_hi      (byte_hi),
        .addr         (addr),
        .wdata        (wdata),
        .a_out        (a_out),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .bhe_n        (bhe_n)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_drive(input logic [1:0] k, input logic su, input logic sl);
        logic rd;
        rd = su ? m_up_dis : (sl ? m_lo_dis : 1'b0);
        return (k == 2'b10) || !(m_strap && rd);
    endfunction

    task automatic do_reset(input logic s);
        rst_n = 1'b0;
        strap_in = s;
        cyc_start = 1'b0;
        cfg_upper_we = 1'b0;
        cfg_lower_we = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R11 reset ad_oe", {31'd0, ad_oe}, 32'd0);
        check_eq("R11 reset bhe_n", {31'd0, bhe_n}, 32'd1);
        check_eq("R11 reset ad_out", {16'd0, ad_out}, 32'd0);
        check_eq("R11 reset a_out", {12'd0, a_out}, 32'd0);
        rst_n = 1'b1;
        m_strap = s;
        m_up_dis = 1'b0;
        m_lo_dis = 1'b0;
        @(negedge clk);
        strap_in = ~s; // R1: must be ignored from now on
    endtask

    task automatic write_cfg(input logic upw, input logic low, input logic b);
        cfg_upper_we = upw;
        cfg_lower_we = low;
        cfg_dis_bit = b;
        @(negedge clk);
        cfg_upper_we = 1'b0;
        cfg_lower_we = 1'b0;
        if (upw) m_up_dis = b;
        if (low) m_lo_dis = b;
    endtask

    task automatic run_cycle(input logic [1:0] k, input logic su, input logic sl,
                             input logic bh, input logic [19:0] ad, input logic [15:0] wd,
                             input logic upw, input logic low, input logic wb,
                             input logic poke);
        logic        drv;
        logic        rf;
        logic        wr;
        logic [15:0] e_ad;
        logic        e_bhe;
        drv = exp_drive(k, su, sl);
        rf = (k == 2'b10);
        wr = (k == 2'b01);
        e_ad = drv ? {ad[15:1], ad[0] | rf} : 16'd0;
        e_bhe = rf ? 1'b1 : ~bh;
        cyc_kind = k; sel_upper = su; sel_lower = sl; byte_hi = bh;
        addr = ad; wdata = wd;
        cfg_upper_we = upw; cfg_lower_we = low; cfg_dis_bit = wb;
        cyc_start = 1'b1;
        @(negedge clk);
        if (upw) m_up_dis = wb;
        if (low) m_lo_dis = wb;
        cfg_upper_we = 1'b0; cfg_lower_we = 1'b0;
        cyc_start = poke;
        if (poke) begin
            addr = ~ad;
            cyc_kind = 2'b01;
        end
        // address phase: R2/R3/R4/R6 drive decision
        check_eq("R2 addr-phase ad_oe", {31'd0, ad_oe}, {31'd0, drv});
        check_eq("R6 addr-phase ad_out", {16'd0, ad_out}, {16'd0, e_ad});
        check_eq("R10 addr-phase bhe_n", {31'd0, bhe_n}, {31'd0, e_bhe});
        check_eq("R5 addr-phase a_out", {12'd0, a_out}, {12'd0, ad});
        @(negedge clk);
        cyc_start = 1'b0;
        check_eq("R7 data-phase ad_oe", {31'd0, ad_oe}, {31'd0, wr});
        check_eq("R7 data-phase ad_out", {16'd0, ad_out}, wr ? {16'd0, wd} : 32'd0);
        check_eq("R10 data-phase bhe_n", {31'd0, bhe_n}, {31'd0, e_bhe});
        check_eq("R8 data-phase a_out", {12'd0, a_out}, {12'd0, ad});
        @(negedge clk);
        check_eq("R7 idle ad_oe", {31'd0, ad_oe}, 32'd0);
        check_eq("R7 idle ad_out", {16'd0, ad_out}, 32'd0);
        check_eq("R7 idle bhe_n", {31'd0, bhe_n}, 32'd1);
        check_eq("R8 idle a_out", {12'd0, a_out}, {12'd0, ad});
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7301));
        // strap high
        do_reset(1'b1);
        run_cycle(2'b00, 1'b1, 1'b0, 1'b1, 20'hABCDE, 16'h0, 0, 0, 0, 0); // R9 reset cfg 0 -> driven
        write_cfg(1'b1, 1'b0, 1'b1);
        run_cycle(2'b00, 1'b1, 1'b0, 1'b0, 20'h12345, 16'h0, 0, 0, 0, 0); // R2 suppressed
        run_cycle(2'b01, 1'b0, 1'b1, 1'b1, 20'h54321, 16'hBEEF, 0, 0, 0, 0); // R2 lower driven
        run_cycle(2'b10, 1'b1, 1'b0, 1'b0, 20'hF0F0E, 16'h0, 0, 0, 0, 0); // R6 refresh overrides
        run_cycle(2'b00, 1'b0, 1'b0, 1'b0, 20'h0FFFF, 16'h0, 0, 0, 0, 0); // R4 other region
        run_cycle(2'b01, 1'b1, 1'b1, 1'b0, 20'h11111, 16'h1234, 0, 0, 0, 0); // R2 upper precedence
        run_cycle(2'b00, 1'b0, 1'b1, 1'b1, 20'h22222, 16'h0, 0, 1, 1, 0); // R9 coincident write uses old
        run_cycle(2'b11, 1'b0, 1'b1, 1'b1, 20'h33333, 16'h0, 0, 0, 0, 0); // R2 lower now suppressed
        run_cycle(2'b01, 1'b0, 1'b0, 1'b1, 20'h44444, 16'hCAFE, 0, 0, 0, 1); // R8 busy start ignored
        for (int i = 0; i < 150; i++) begin
            run_cycle(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      20'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom));
        end
        // strap low: R1 (previous strap and later pin changes ignored), R3
        do_reset(1'b0);
        write_cfg(1'b1, 1'b1, 1'b1);
        run_cycle(2'b00, 1'b1, 1'b0, 1'b0, 20'h9ABCD, 16'h0, 0, 0, 0, 0); // R3
        run_cycle(2'b00, 1'b0, 1'b1, 1'b0, 20'h8ACE0, 16'h0, 0, 0, 0, 0); // R3
        for (int i = 0; i < 150; i++) begin
            run_cycle(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      20'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom));
        end
        // strap high again with strap pin toggled after release: R1
        do_reset(1'b1);
        write_cfg(1'b0, 1'b1, 1'b1);
        run_cycle(2'b00, 1'b0, 1'b1, 1'b0, 20'h76543, 16'h0, 0, 0, 0, 0); // R1 high kept
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule